// File: doc/BRIEF.md
# Transmit Cell Integrity Checker

This block watches the byte-wide cell stream that leaves a transmit cell FIFO. It keeps an octet counter that restarts on a start-of-cell marker. At the integrity octet, which is octet 5 of each 53-octet cell, it compares the byte against an expected pattern. The pattern is selected by a control bit. A mismatch raises a sticky status flag, but only while the error interrupt is enabled.

The flag is mirrored as a summary bit in a global interrupt status register, which drives an active-high interrupt line. Reading the local control register returns the flag and then clears both the flag and the summary bit. The remaining control bits cover scrambling, coset, HEC insertion, GFC insertion and idle-cell HEC calculation. These bits are only stored and driven out to neighbouring logic.

A single register port serves both registers. It has a write strobe, a read strobe, an address and a write-data byte. Read data is combinational from the address.

Top module: `txcp_integrity_chk`

## Requirements
- R1: When the error interrupt enable (control bit 2) is 1, a byte at octet 5 that differs from the expected pattern sets the status bit (control bit 0) at the clock edge that accepts that byte.
- R2: The expected pattern is 0x55 when the pattern-select bit (control bit 4) is 0, and 0xAA when it is 1.
- R3: Octets are numbered from 1 on a valid byte with start-of-cell high. Numbering wraps back to 1 after octet 53, so a following cell without a marker is still checked. A marker in the middle of a cell restarts the count.
- R4: Control bits 7..1 are read/write, and bit 0 ignores writes. Bits 7, 6, 5, 3 and 1 drive the scrambler, coset, HEC-insert, GFC-insert and idle-HEC enable outputs respectively.
- R5: While the error interrupt enable is 0, a mismatch leaves the status bit, the summary bit and the interrupt at 0.
- R6: A read of the control register (address 0x10) returns the status bit as it stood before the read. It then clears the status bit and the summary bit.
- R7: A mismatch in the same cycle as a control register read leaves the status bit set after that read.
- R8: The global status register (address 0x04) carries the summary bit at bit 2 and zeros elsewhere. Reading it clears nothing.
- R9: irq_o is high exactly while the summary bit is set and the error interrupt enable is 1.
- R10: After reset, every control bit, the status bit, the summary bit and irq_o are 0.
- R11: Bytes at octet positions other than 5 never raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_valid_i | input | 1 | A cell byte is present this cycle |
| cell_soc_i | input | 1 | Present byte is octet 1 of a cell |
| cell_data_i | input | 8 | Cell byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears on control read) |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| scram_en_o | output | 1 | Scrambler enable |
| coset_en_o | output | 1 | Coset enable |
| hec_ins_en_o | output | 1 | HEC insert enable |
| gfc_ins_en_o | output | 1 | GFC insert enable |
| idle_hec_en_o | output | 1 | Idle-cell HEC calculation enable |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with its default parameters: 53-octet cells, check at octet 5, patterns 0x55 and 0xAA, and summary bit 2. With these defaults the full cell length is short enough to stream back-to-back cells. That brings the counter wrap, restart on a mid-cell marker, and off-position mismatches within reach. The fixed addresses let directed reads hit the read-clear and the read-during-mismatch collision in a chosen cycle.

// File: rtl/txcp_chk_pkg.sv
package txcp_chk_pkg;
  typedef struct packed {
    logic scram_en;
    logic coset_en;
    logic hec_ins_en;
    logic pat_sel;
    logic gfc_ins_en;
    logic err_ie;
    logic idle_hec_en;
    logic err_st;
  } txcp_ctrl_t;

  localparam int unsigned CTRL_W = $bits(txcp_ctrl_t);
endpackage

// File: rtl/cell_octet_tracker.sv
module cell_octet_tracker #(
  parameter int unsigned CELL_LEN  = 53,
  parameter int unsigned CHECK_POS = 5,
  localparam int unsigned IDX_W    = $clog2(CELL_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             soc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             at_check_o
);
  localparam logic [IDX_W-1:0] LenC = IDX_W'(CELL_LEN);
  localparam logic [IDX_W-1:0] PosC = IDX_W'(CHECK_POS);
  localparam logic [IDX_W-1:0] OneC = IDX_W'(1);

  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] cur_idx;

  // index of the byte on the input this cycle
  always_comb begin
    if (soc_i || cnt_q == LenC) cur_idx = OneC;
    else                        cur_idx = cnt_q + OneC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= cur_idx;
  end

  assign idx_o      = cur_idx;
  assign at_check_o = valid_i && (cur_idx == PosC);
endmodule

// File: rtl/integ_pattern_cmp.sv
module integ_pattern_cmp #(
  parameter int unsigned          DATA_W = 8,
  parameter logic [DATA_W-1:0]    PAT0   = 8'h55,
  parameter logic [DATA_W-1:0]    PAT1   = 8'hAA
) (
  input  logic              check_i,
  input  logic              pat_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mismatch_o
);
  logic [DATA_W-1:0] exp_pat;

  assign exp_pat    = pat_sel_i ? PAT1 : PAT0;
  assign mismatch_o = check_i && (data_i != exp_pat);
endmodule

// File: rtl/txcp_ctrl_reg.sv
module txcp_ctrl_reg
  import txcp_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              set_i,
  output txcp_ctrl_t        ctrl_o
);
  txcp_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i) ctrl_q[CTRL_W-1:1] <= wdata_i[CTRL_W-1:1];
      // set wins over read-clear so a colliding event survives
      ctrl_q.err_st <= set_i | (ctrl_q.err_st & ~clr_i);
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/glb_irq_summary.sv
module glb_irq_summary #(
  parameter int unsigned STAT_W  = 8,
  parameter int unsigned SRC_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              en_i,
  output logic              sum_o,
  output logic [STAT_W-1:0] gstat_o,
  output logic              irq_o
);
  logic sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= set_i | (sum_q & ~clr_i);
  end

  for (genvar g = 0; g < STAT_W; g++) begin : g_stat
    if (g == SRC_BIT) begin : g_src
      assign gstat_o[g] = sum_q;
    end else begin : g_nil
      assign gstat_o[g] = 1'b0;
    end
  end

  assign sum_o = sum_q;
  assign irq_o = sum_q & en_i;
endmodule

// File: rtl/txcp_integrity_chk.sv
module txcp_integrity_chk
  import txcp_chk_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_LEN   = 53,
  parameter int unsigned CHECK_POS  = 5,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] GSTAT_ADDR = 8'h04,
  parameter int unsigned SUM_BIT    = 2,
  localparam int unsigned IDX_W     = $clog2(CELL_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_valid_i,
  input  logic              cell_soc_i,
  input  logic [DATA_W-1:0] cell_data_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic              scram_en_o,
  output logic              coset_en_o,
  output logic              hec_ins_en_o,
  output logic              gfc_ins_en_o,
  output logic              idle_hec_en_o,
  output logic              irq_o
);
  txcp_ctrl_t        ctrl_q;
  logic [IDX_W-1:0]  octet_idx;
  logic              at_check;
  logic              mismatch;
  logic              err_evt;
  logic              rd_ctrl;
  logic              wr_ctrl;
  logic              sum_q;
  logic              err_ie;
  logic              stat_q;
  logic [CTRL_W-1:0] gstat;

  assign rd_ctrl = reg_rd_i && (reg_addr_i == CTRL_ADDR);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == CTRL_ADDR);
  assign err_ie  = ctrl_q.err_ie;
  assign stat_q  = ctrl_q.err_st;
  assign err_evt = mismatch && err_ie;

  cell_octet_tracker #(
    .CELL_LEN (CELL_LEN),
    .CHECK_POS(CHECK_POS)
  ) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cell_valid_i),
    .soc_i     (cell_soc_i),
    .idx_o     (octet_idx),
    .at_check_o(at_check)
  );

  integ_pattern_cmp #(
    .DATA_W(DATA_W)
  ) u_cmp (
    .check_i   (at_check),
    .pat_sel_i (ctrl_q.pat_sel),
    .data_i    (cell_data_i),
    .mismatch_o(mismatch)
  );

  txcp_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_ctrl),
    .wdata_i(reg_wdata_i),
    .clr_i  (rd_ctrl),
    .set_i  (err_evt),
    .ctrl_o (ctrl_q)
  );

  glb_irq_summary #(
    .STAT_W (CTRL_W),
    .SRC_BIT(SUM_BIT)
  ) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_evt),
    .clr_i  (rd_ctrl),
    .en_i   (err_ie),
    .sum_o  (sum_q),
    .gstat_o(gstat),
    .irq_o  (irq_o)
  );

  always_comb begin
    if (reg_addr_i == CTRL_ADDR)       reg_rdata_o = ctrl_q;
    else if (reg_addr_i == GSTAT_ADDR) reg_rdata_o = gstat;
    else                               reg_rdata_o = '0;
  end

  assign scram_en_o    = ctrl_q.scram_en;
  assign coset_en_o    = ctrl_q.coset_en;
  assign hec_ins_en_o  = ctrl_q.hec_ins_en;
  assign gfc_ins_en_o  = ctrl_q.gfc_ins_en;
  assign idle_hec_en_o = ctrl_q.idle_hec_en;
endmodule

// File: rtl/txcp_integrity_chk_sva.sv
module txcp_integrity_chk_sva #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned IDX_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             err_ie,
  input logic             stat_q,
  input logic             sum_q,
  input logic             err_evt,
  input logic             rd_ctrl,
  input logic             cell_valid,
  input logic [IDX_W-1:0] octet_idx
);
  p_irq_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> err_ie);

  p_sum_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q == sum_q);

  p_keep_on_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt |=> stat_q);

  p_rd_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && !err_evt) |=> !stat_q);

  p_stat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ctrl && !err_evt) |=> stat_q == $past(stat_q));

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid |-> (octet_idx >= 1 && octet_idx <= IDX_W'(CELL_LEN)));

  p_irq_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(err_evt) || $past(!err_ie)));
endmodule

bind txcp_integrity_chk txcp_integrity_chk_sva #(
  .CELL_LEN(CELL_LEN),
  .IDX_W   (IDX_W)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .err_ie    (err_ie),
  .stat_q    (stat_q),
  .sum_q     (sum_q),
  .err_evt   (err_evt),
  .rd_ctrl   (rd_ctrl),
  .cell_valid(cell_valid_i),
  .octet_idx (octet_idx)
);

// File: tb/tb_txcp_integrity_chk.sv
`timescale 1ns/1ps
module tb_txcp_integrity_chk;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_GST  = 8'h04;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, soc = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] data = '0, addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       scram, coset, hec, gfc, idle, irq;
  int         n_chk = 0, n_err = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  txcp_integrity_chk dut (
    .clk_i(clk), .rst_ni(rst_n), .cell_valid_i(valid), .cell_soc_i(soc),
    .cell_data_i(data), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scram_en_o(scram),
    .coset_en_o(coset), .hec_ins_en_o(hec), .gfc_ins_en_o(gfc),
    .idle_hec_en_o(idle), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // rd_at: octet at which a control read is issued (0 = none)
  task automatic send_cell(logic [7:0] b5, logic [7:0] fill, bit use_soc,
                           bit close, int rd_at, output logic [7:0] rcap);
    rcap = '0;
    for (int i = 1; i <= 53; i++) begin
      @(negedge clk);
      valid = 1'b1; soc = use_soc && (i == 1);
      data  = (i == 5) ? b5 : fill;
      rd = (i == rd_at); addr = A_CTRL;
      #1 if (i == rd_at) rcap = rdata;
    end
    if (close) begin
      @(negedge clk); valid = 1'b0; soc = 1'b0; rd = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd_reg(A_CTRL, rv); chk("R10 ctrl", rv, 8'h00);
    rd_reg(A_GST, rv);  chk("R10 gstat", rv, 8'h00);
    chk("R10 irq/outs", {2'b0, irq, scram, coset, hec, gfc, idle}, 8'h00);
  endtask

  task automatic t_rw();
    wr_reg(A_CTRL, 8'hFF);
    rd_reg(A_CTRL, rv); chk("R4 rw bit0 ro", rv, 8'hFE);
    chk("R4 outs", {3'b0, scram, coset, hec, gfc, idle}, 8'h1F);
    wr_reg(A_CTRL, 8'hA1);
    rd_reg(A_CTRL, rv); chk("R4 bit0 ignored", rv, 8'hA0);
    chk("R4 outs map", {3'b0, scram, coset, hec, gfc, idle}, 8'h14);
    wr_reg(A_CTRL, 8'h04);
  endtask

  task automatic t_fifth();
    send_cell(8'h55, 8'h00, 1, 1, 0, rv);
    chk("R11 good cell irq", {7'b0, irq}, 8'h00);
    send_cell(8'h12, 8'h55, 1, 1, 0, rv);
    chk("R1 mismatch irq", {7'b0, irq}, 8'h01);
    rd_reg(A_GST, rv); chk("R8 gstat bit2", rv, 8'h04);
    rd_reg(A_GST, rv); chk("R8 gstat no clear", rv, 8'h04);
    rd_reg(A_CTRL, rv); chk("R6 read old status", rv, 8'h05);
    rd_reg(A_CTRL, rv); chk("R6 cleared", rv, 8'h04);
    rd_reg(A_GST, rv);  chk("R6 summary cleared", rv, 8'h00);
    chk("R9 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_patsel();
    wr_reg(A_CTRL, 8'h14);
    send_cell(8'hAA, 8'h55, 1, 1, 0, rv);
    chk("R2 sel1 AA ok", {7'b0, irq}, 8'h00);
    send_cell(8'h55, 8'hAA, 1, 1, 0, rv);
    chk("R2 sel1 55 err", {7'b0, irq}, 8'h01);
    rd_reg(A_CTRL, rv); chk("R2 status", rv, 8'h15);
  endtask

  task automatic t_disabled();
    wr_reg(A_CTRL, 8'h10);
    send_cell(8'h00, 8'h00, 1, 1, 0, rv);
    rd_reg(A_CTRL, rv); chk("R5 status stays 0", rv, 8'h10);
    rd_reg(A_GST, rv);  chk("R5 summary 0", rv, 8'h00);
    chk("R5 irq 0", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_wrap();
    wr_reg(A_CTRL, 8'h04);
    send_cell(8'h55, 8'h00, 1, 0, 0, rv);
    send_cell(8'h55, 8'h00, 0, 1, 0, rv);
    chk("R3 wrap good", {7'b0, irq}, 8'h00);
    send_cell(8'h55, 8'h00, 1, 0, 0, rv);
    send_cell(8'h99, 8'h55, 0, 1, 0, rv);
    chk("R3 wrap bad", {7'b0, irq}, 8'h01);
    rd_reg(A_CTRL, rv);
    // partial cell then resync on marker
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); valid = 1'b1; soc = (i == 1); data = 8'h55;
    end
    send_cell(8'h55, 8'h00, 1, 1, 0, rv);
    chk("R3 resync", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_collide();
    send_cell(8'h33, 8'h55, 1, 1, 5, rv);
    chk("R7 read value", rv, 8'h04);
    rd_reg(A_CTRL, rv); chk("R7 kept", rv, 8'h05);
  endtask

  task automatic t_mask();
    send_cell(8'h01, 8'h55, 1, 1, 0, rv);
    chk("R9 irq set", {7'b0, irq}, 8'h01);
    wr_reg(A_CTRL, 8'h00);
    #1 chk("R9 irq masked", {7'b0, irq}, 8'h00);
    rd_reg(A_GST, rv); chk("R9 pending kept", rv, 8'h04);
    rd_reg(A_CTRL, rv); chk("R9 status", rv, 8'h01);
    rd_reg(A_GST, rv); chk("R9 cleared", rv, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_fifth();
    t_patsel();
    t_disabled();
    t_wrap();
    t_collide();
    t_mask();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule